// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

This block lands incoming frames from a byte stream into buffers named by a ring of descriptors, all held in one 32-bit word memory. Software shares that memory through a host port. Each descriptor takes four words at word address 4·i, for i from 0 to NDESC−1:

- Word 0 is the status word.
- Word 1 is a tag word.
- Word 2 is the buffer byte address.
- Word 3 is the upper address word.

Software arms a descriptor by writing its status word. That word carries the ownership bit (bit 31), the buffer size in bytes (bits 12:0) and, if wanted, the end-of-ring bit (bit 30). Software then waits for bit 31 to read back as zero.

At the first byte of a frame, the engine checks the current descriptor. If the descriptor is armed, the engine writes the frame into its buffer byte by byte. On the last byte, in the same clock, it writes back the status word. The written-back word has ownership released, the received length including the 4-byte CRC, and the error flags. It then moves to the next descriptor.

A frame that arrives while the current descriptor still belongs to software is dropped, and an overflow event is recorded. Events appear in a sticky interrupt status vector that is cleared by writing 1 to its bits.

Top module: `rxr_writeback`

## Requirements
- R1: When the current descriptor has bit 31 set at a frame's first byte, byte k of the frame (k counted from 0) is written to memory byte address A+k. A is descriptor word 2. Byte address b lands in word b>>2, lane b[1:0], and lane n occupies bits 8n+7:8n.
- R2: In the same clock as the frame's last byte, the status word is written back as follows: bit 31 = 0; bit 30 kept as armed; bits 29 and 28 = 1; bits 12:0 = number of bytes received; all other bits 0 unless R3 to R5 set them. The new value is readable on the host port in the next cycle.
- R3: If a frame is longer than the buffer size (bits 12:0 of the armed status), bytes at offsets from the size onward are not written. The written-back length equals the buffer size, and bits 22 and 21 are set.
- R4: A frame shorter than MIN_FRAME bytes sets bits 20 and 21 of the written-back status.
- R5: When in_crc_err is high with the last byte, bits 19 and 21 of the written-back status are set.
- R6: After a writeback the ring index advances by one. It returns to 0 after an entry armed with bit 30, or after entry NDESC−1.
- R7: If bit 31 of the current descriptor is clear at a frame's first byte, the whole frame is discarded, no memory word changes, the ring index stays, and irq_status bit 4 is set. The same descriptor is checked again at the next frame's first byte.
- R8: A writeback without bit 21 sets irq_status bit 0. A writeback with bit 21 sets irq_status bit 1.
- R9: irq_status bits hold until a cycle with the matching irq_clr bit high clears them. If a set and a clear of the same bit meet in one cycle, the set wins.
- R10: Writeback leaves descriptor words 1, 2 and 3 unchanged.
- R11: After reset, irq_status is 0 and the ring index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | This byte ends the frame (the CRC is counted in the frame) |
| in_crc_err | input | 1 | CRC mismatch flag, sampled with the last byte |
| host_we | input | 1 | Host word write strobe |
| host_addr | input | AW | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Word at host_addr (combinational read) |
| irq_clr | input | 16 | Write-1-to-clear mask for irq_status |
| irq_status | output | 16 | Sticky events: bit 0 good frame, bit 1 errored frame, bit 4 frame dropped |

## Verification
A wrong ring index shows up at the very first byte of the next frame. The frame is either dropped, which sets irq bit 4 at once, or written into a descriptor the bench did not arm, and the very next host read shows it. A miscounting byte counter or a lost size latch shows in the length field and in the preserved guard bytes of the buffer, readable one cycle after the last byte. A stale ownership latch shows as a whole frame written into a buffer that software still holds, with its status untouched.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   // status word fields
   localparam int ST_OWN  = 31;
   localparam int ST_EOR  = 30;
   localparam int ST_FS   = 29;
   localparam int ST_LS   = 28;
   localparam int ST_LONG = 22;
   localparam int ST_ERR  = 21;
   localparam int ST_RUNT = 20;
   localparam int ST_CRC  = 19;
   localparam int LEN_W   = 13;
   // byte counter, one bit wider than the length field so it can exceed it
   localparam int CNT_W   = LEN_W + 1;
   // event vector
   localparam int IRQ_W   = 16;
   localparam int IRQ_OK  = 0;
   localparam int IRQ_ERR = 1;
   localparam int IRQ_OVF = 4;
endpackage

// File: rtl/rxr_mem.sv
module rxr_mem #(
   parameter int WORDS = 256,
   parameter int AW    = 8,
   parameter int BAW   = 10
) (
   input  logic             clk,
   input  logic             host_we,
   input  logic [AW-1:0]    host_addr,
   input  logic [31:0]      host_wdata,
   output logic [31:0]      host_rdata,
   input  logic             byte_we,
   input  logic [BAW-1:0]   byte_addr,
   input  logic [7:0]       byte_data,
   input  logic             stat_we,
   input  logic [31:0]      stat_wdata,
   input  logic [AW-1:0]    desc_addr,
   output logic             desc_own,
   output logic             desc_eor,
   output logic [12:0]      desc_size,
   output logic [BAW-1:0]   desc_base
);
   logic [31:0] mem [WORDS];
   logic [3:0]  lane_en;

   for (genvar l = 0; l < 4; l++) begin : g_lane
      assign lane_en[l] = byte_we && (byte_addr[1:0] == 2'(l));
   end

   // later statements win: engine writes override a colliding host write
   always_ff @(posedge clk) begin
      if (host_we) mem[host_addr] <= host_wdata;
      for (int l = 0; l < 4; l++)
         if (lane_en[l]) mem[byte_addr[BAW-1:2]][l*8 +: 8] <= byte_data;
      if (stat_we) mem[desc_addr] <= stat_wdata;
   end

   assign host_rdata = mem[host_addr];
   assign desc_own   = mem[desc_addr][31];
   assign desc_eor   = mem[desc_addr][30];
   assign desc_size  = mem[desc_addr][12:0];
   assign desc_base  = mem[desc_addr + AW'(2)][BAW-1:0];
endmodule

// File: rtl/rxr_frame.sv
module rxr_frame
   import rxr_pkg::*;
#(
   parameter int BAW       = 10,
   parameter int MIN_FRAME = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_last,
   input  logic             in_crc_err,
   input  logic             desc_own,
   input  logic             desc_eor,
   input  logic [LEN_W-1:0] desc_size,
   input  logic [BAW-1:0]   desc_base,
   output logic             byte_we,
   output logic [BAW-1:0]   byte_addr,
   output logic             wb_en,
   output logic             wb_err,
   output logic             wb_eor,
   output logic [31:0]      wb_stat,
   output logic             drop_evt
);
   localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_FRAME);

   logic             active_q, keep_q, eor_q;
   logic [LEN_W-1:0] size_q;
   logic [BAW-1:0]   base_q;
   logic [CNT_W-1:0] cnt_q;

   logic             sof, keep, eor;
   logic [LEN_W-1:0] size, len;
   logic [BAW-1:0]   base;
   logic [CNT_W-1:0] cnt, cnt_inc;
   logic             trunc, runt;

   // descriptor context comes straight from memory on the first byte
   assign sof  = in_valid && !active_q;
   assign keep = sof ? desc_own  : keep_q;
   assign eor  = sof ? desc_eor  : eor_q;
   assign size = sof ? desc_size : size_q;
   assign base = sof ? desc_base : base_q;
   assign cnt  = sof ? '0        : cnt_q;

   assign cnt_inc   = (&cnt) ? cnt : cnt + 1'b1;
   assign byte_we   = in_valid && keep && (cnt < {1'b0, size});
   assign byte_addr = base + BAW'(cnt);
   assign trunc     = cnt_inc > {1'b0, size};
   assign runt      = cnt_inc < MIN_C;
   assign len       = trunc ? size : cnt_inc[LEN_W-1:0];

   assign wb_en    = in_valid && in_last && keep;
   assign wb_err   = trunc || runt || in_crc_err;
   assign wb_eor   = eor;
   assign drop_evt = sof && !desc_own;

   always_comb begin
      wb_stat              = '0;
      wb_stat[ST_EOR]      = eor;
      wb_stat[ST_FS]       = 1'b1;
      wb_stat[ST_LS]       = 1'b1;
      wb_stat[ST_LONG]     = trunc;
      wb_stat[ST_ERR]      = wb_err;
      wb_stat[ST_RUNT]     = runt;
      wb_stat[ST_CRC]      = in_crc_err;
      wb_stat[LEN_W-1:0]   = len;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         keep_q   <= 1'b0;
         eor_q    <= 1'b0;
         size_q   <= '0;
         base_q   <= '0;
         cnt_q    <= '0;
      end else if (in_valid) begin
         active_q <= !in_last;
         keep_q   <= keep;
         eor_q    <= eor;
         size_q   <= size;
         base_q   <= base;
         cnt_q    <= cnt_inc;
      end
   end
endmodule

// File: rtl/rxr_ring.sv
module rxr_ring #(
   parameter int NDESC = 4,
   parameter int IDXW  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            advance,
   input  logic            eor,
   output logic [IDXW-1:0] idx
);
   logic [IDXW-1:0] nxt;

   if ((NDESC & (NDESC - 1)) == 0) begin : g_pow2
      // index width matches the ring, natural overflow wraps it
      assign nxt = eor ? '0 : idx + 1'b1;
   end else begin : g_cmp
      assign nxt = (eor || idx == IDXW'(NDESC - 1)) ? '0 : idx + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       idx <= '0;
      else if (advance) idx <= nxt;
   end
endmodule

// File: rtl/rxr_irq.sv
module rxr_irq #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr) | set;
   end
endmodule

// File: rtl/rxr_writeback.sv
module rxr_writeback
   import rxr_pkg::*;
#(
   parameter int  MEM_WORDS = 256,
   parameter int  NDESC     = 4,
   parameter int  MIN_FRAME = 64,
   localparam int AW        = $clog2(MEM_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   input  logic             in_last,
   input  logic             in_crc_err,
   input  logic             host_we,
   input  logic [AW-1:0]    host_addr,
   input  logic [31:0]      host_wdata,
   output logic [31:0]      host_rdata,
   input  logic [IRQ_W-1:0] irq_clr,
   output logic [IRQ_W-1:0] irq_status
);
   localparam int BAW  = AW + 2;
   localparam int IDXW = (NDESC > 1) ? $clog2(NDESC) : 1;

   initial begin
      assert (NDESC >= 2) else $error("ring needs at least two descriptors");
      assert (NDESC * 4 <= MEM_WORDS) else $error("ring does not fit in memory");
      assert (MIN_FRAME > 0 && MIN_FRAME < (1 << LEN_W)) else $error("bad minimum frame");
   end

   logic [IDXW-1:0]  ring_idx;
   logic [AW-1:0]    desc_addr;
   logic             desc_own, desc_eor;
   logic [LEN_W-1:0] desc_size;
   logic [BAW-1:0]   desc_base;
   logic             byte_we, wb_en, wb_err, wb_eor, drop_evt;
   logic [BAW-1:0]   byte_addr;
   logic [31:0]      wb_stat;
   logic [IRQ_W-1:0] irq_set;

   assign desc_addr = AW'({ring_idx, 2'b00});

   always_comb begin
      irq_set          = '0;
      irq_set[IRQ_OK]  = wb_en && !wb_err;
      irq_set[IRQ_ERR] = wb_en && wb_err;
      irq_set[IRQ_OVF] = drop_evt;
   end

   rxr_mem #(.WORDS(MEM_WORDS), .AW(AW), .BAW(BAW)) u_mem (
      .clk(clk), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .byte_we(byte_we), .byte_addr(byte_addr), .byte_data(in_data),
      .stat_we(wb_en), .stat_wdata(wb_stat), .desc_addr(desc_addr),
      .desc_own(desc_own), .desc_eor(desc_eor),
      .desc_size(desc_size), .desc_base(desc_base)
   );

   rxr_frame #(.BAW(BAW), .MIN_FRAME(MIN_FRAME)) u_frame (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
      .in_crc_err(in_crc_err), .desc_own(desc_own), .desc_eor(desc_eor),
      .desc_size(desc_size), .desc_base(desc_base), .byte_we(byte_we),
      .byte_addr(byte_addr), .wb_en(wb_en), .wb_err(wb_err),
      .wb_eor(wb_eor), .wb_stat(wb_stat), .drop_evt(drop_evt)
   );

   rxr_ring #(.NDESC(NDESC), .IDXW(IDXW)) u_ring (
      .clk(clk), .rst_n(rst_n), .advance(wb_en), .eor(wb_eor), .idx(ring_idx)
   );

   rxr_irq #(.W(IRQ_W)) u_irq (
      .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(irq_clr), .q(irq_status)
   );
endmodule

// File: rtl/rxr_writeback_chk.sv
module rxr_writeback_chk #(
   parameter int IDXW = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            in_last,
   input logic [15:0]     irq_clr,
   input logic [15:0]     irq_status,
   input logic [IDXW-1:0] ring_idx
);
   // R8
   rxok_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_status[0]) |-> $past(in_valid && in_last));

   // R7
   ovf_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_status[4]) |-> $past(in_valid));

   // R9
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_status[0] && !irq_clr[0]) |=> irq_status[0]);

   // R9
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr[0] && !(in_valid && in_last)) |=> !irq_status[0]);

   // R6
   idx_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ring_idx) |-> $past(in_valid && in_last));
endmodule

bind rxr_writeback rxr_writeback_chk #(.IDXW(IDXW)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
   .irq_clr(irq_clr), .irq_status(irq_status), .ring_idx(ring_idx)
);

// File: tb/rxr_writeback_tb.sv
`timescale 1ns/1ps
module rxr_writeback_tb;
   localparam int WORDS = 256;
   localparam int ND    = 4;
   localparam int MINF  = 64;
   localparam int AW    = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_last = 1'b0, in_crc_err = 1'b0;
   logic [7:0]  in_data = '0;
   logic        host_we = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic [15:0] irq_clr = '0;
   logic [15:0] irq_status;

   int total = 0;
   int bad   = 0;
   int exp_idx = 0;

   always #4 clk = ~clk;

   rxr_writeback #(.MEM_WORDS(WORDS), .NDESC(ND), .MIN_FRAME(MINF)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .in_crc_err(in_crc_err), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .irq_clr(irq_clr), .irq_status(irq_status)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", what, act, exp);
      end
   endtask

   task automatic hwr(input int a, input logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic hrd(input int a, output logic [31:0] d);
      @(negedge clk);
      host_addr = AW'(a);
      #1 d = host_rdata;
   endtask

   function automatic int bufw(input int d);
      return 64 + 32 * d;
   endfunction

   function automatic logic [7:0] pat(input int seed, input int k);
      return 8'(seed * 16 + k * 3 + 1);
   endfunction

   task automatic arm(input int d, input int size, input int off, input bit eor);
      for (int w = 0; w < 32; w++) hwr(bufw(d) + w, 32'hA5A5_A5A5);
      hwr(4*d + 1, 32'hC0DE_0000 | d);
      hwr(4*d + 2, bufw(d) * 4 + off);
      hwr(4*d + 3, 32'h1234_5670 | d);
      hwr(4*d, (32'h1 << 31) | (32'(eor) << 30) | 32'(size));
   endtask

   task automatic send(input int len, input int seed, input bit crc, input bit clr_last);
      for (int k = 0; k < len; k++) begin
         @(negedge clk);
         in_valid   = 1'b1;
         in_data    = pat(seed, k);
         in_last    = (k == len - 1);
         in_crc_err = crc && (k == len - 1);
         irq_clr    = (clr_last && k == len - 1) ? 16'hFFFF : 16'h0;
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0; in_crc_err = 1'b0; irq_clr = '0;
   endtask

   task automatic clear_irq();
      @(negedge clk); irq_clr = 16'hFFFF;
      @(negedge clk); irq_clr = 16'h0;
      #1 chk("R9 cleared by write-1", 32'(irq_status), 32'h0);
   endtask

   task automatic check_frame(input int d, input int size, input int off, input bit eor,
                              input int len, input int seed, input bit crc);
      logic [31:0] rd, ew;
      int wr;
      bit tr, ru, er;
      wr = (len < size) ? len : size;
      tr = (len > size);
      ru = (len < MINF);
      er = tr || ru || crc;
      ew = (32'(eor) << 30) | (32'h3 << 28) | (32'(tr) << 22) | (32'(er) << 21)
         | (32'(ru) << 20) | (32'(crc) << 19) | 32'(wr);
      hrd(4*d, rd);
      chk($sformatf("R2 R3 R4 R5 status d=%0d len=%0d", d, len), rd, ew);
      hrd(4*d + 1, rd);
      chk("R10 tag word", rd, 32'hC0DE_0000 | d);
      hrd(4*d + 2, rd);
      chk("R10 address word", rd, bufw(d) * 4 + off);
      hrd(4*d + 3, rd);
      chk("R10 upper word", rd, 32'h1234_5670 | d);
      for (int w = 0; w < 32; w++) begin
         ew = '0;
         for (int ln = 0; ln < 4; ln++) begin
            int rel;
            rel = w * 4 + ln - off;
            ew[ln*8 +: 8] = (rel >= 0 && rel < wr) ? pat(seed, rel) : 8'hA5;
         end
         hrd(bufw(d) + w, rd);
         chk($sformatf("R1 R3 buffer d=%0d w=%0d", d, w), rd, ew);
      end
      chk("R8 R9 sticky event", 32'(irq_status), er ? 32'h2 : 32'h1);
      clear_irq();
   endtask

   task automatic frame(input int size, input int off, input bit eor,
                        input int len, input int seed, input bit crc);
      arm(exp_idx, size, off, eor);
      send(len, seed, crc, 1'b0);
      check_frame(exp_idx, size, off, eor, len, seed, crc);
      exp_idx = (eor || exp_idx == ND - 1) ? 0 : exp_idx + 1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int lens[12] = '{1, 3, 4, 5, 63, 64, 65, 99, 100, 101, 120, 128};
      logic [31:0] s0, b0, rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1 chk("R11 reset events", 32'(irq_status), 32'h0);

      // R1 R2 R3 R4 R6 R8: sweep lengths across the size edge and all lane offsets;
      // first frame must land in descriptor 0 (R11)
      for (int off = 0; off < 4; off++)
         for (int li = 0; li < 12; li++)
            frame(100, off, exp_idx == ND - 1, lens[li], li + off * 16, 1'b0);

      // R5 CRC flag
      frame(100, 1, exp_idx == ND - 1, 70, 7, 1'b1);
      frame(100, 0, exp_idx == ND - 1, 40, 9, 1'b1);

      // R7 drop when current descriptor is still software-owned
      hrd(4*exp_idx, s0);
      hrd(bufw(exp_idx), b0);
      send(70, 3, 1'b0, 1'b0);
      chk("R7 overflow event", 32'(irq_status), 32'h10);
      hrd(4*exp_idx, rd);
      chk("R7 status untouched", rd, s0);
      hrd(bufw(exp_idx), rd);
      chk("R7 buffer untouched", rd, b0);
      clear_irq();
      // R7 same descriptor taken once armed
      frame(90, 2, 1'b0, 80, 5, 1'b0);

      // R6 early wrap on end-of-ring entry that is not the last index
      if (exp_idx == ND - 1) frame(100, 0, 1'b1, 66, 2, 1'b0);
      begin
         int decoy;
         decoy = exp_idx + 1;
         arm(decoy, 100, 0, 1'b0);
         frame(100, 0, 1'b1, 70, 11, 1'b0);
         chk("R6 wrap index", 32'(exp_idx), 32'h0);
         frame(100, 3, 1'b0, 72, 12, 1'b0);
         hrd(4*decoy, rd);
         chk("R6 decoy still armed", rd, (32'h1 << 31) | 32'd100);
      end

      // R9 set wins over same-cycle clear
      arm(exp_idx, 100, 0, 1'b0);
      send(68, 13, 1'b0, 1'b1);
      chk("R9 set wins", 32'(irq_status), 32'h1);
      check_frame(exp_idx, 100, 0, 1'b0, 68, 13, 1'b0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule